// File: doc/BRIEF.md
# Configurable FPM DRAM Random-Cycle Sequencer

This block runs one random read or write access to a fast-page-mode DRAM at a time. A host presents an address, a read/write flag and write data with a valid/ready handshake. The sequencer then produces the row address strobe, column address strobe, write strobe, output enable, the multiplexed row/column address and the write-data drive enable. When the access completes it returns the read data together with a one-tick done pulse.

The block is clocked by a tick clock at twice the memory clock rate, so one tick is half a memory clock. All delays are whole tick counts. Three configuration inputs set the timing, and they are captured when a request is accepted:
- a 2-bit row-timing field sets the row address setup and the precharge;
- a one-bit short-delay flag shortens the strobe-to-strobe delay;
- a 2-bit cycle-length field sets the minimum total access length.

Page bursts, refresh and arbitration are handled elsewhere.

Top module: `fpm_cycle_seq`

## Requirements
- R1: While reset is asserted and afterwards until a request arrives, all four strobes are high (inactive), the column select and the data drive enable are 0, req_ready is 1 and rsp_done is 0.
- R2: A request is accepted only on a clock edge where req_ready is 1, which happens only when the block is idle. A request held while an access is in progress starts no extra row strobe. The configuration is captured at acceptance, so a change during an access has no effect on that access.
- R3: The row strobe falls S ticks after the acceptance edge. S is 4 for row-timing 00 and 11, 3 for 01 and 2 for 10. The row address is on the bus during that time.
- R4: The column strobe falls D ticks after the row strobe falls. For row-timing 01, D is 2 when the short-delay flag is 1 and 4 when it is 0. For any other row-timing value, D is 3 when the flag is 1 and 5 when it is 0. The column strobe is low only while the row strobe is low.
- R5: The address bus switches from row to column one tick before the column strobe falls. The column select output is 1 from that tick onward. This gives one tick of column setup, and a row hold of D-1 ticks.
- R6: The row strobe stays low for L = max(D+2, C-S) ticks. C is 10 ticks for cycle-length 00 and 11, 8 for 01 and 6 for 10.
- R7: The row and column strobes rise together. rsp_done is 1 for exactly that one tick, and req_ready is 1 again in the same tick.
- R8: On a write, the write strobe falls together with the column select. dram_dq_oe rises one tick later, carrying the request's write data, and stays high until the strobes rise. The output enable stays high throughout.
- R9: On a read, the output enable falls together with the column strobe and the write strobe stays high. rsp_rdata takes dram_dq_in as sampled on the edge that ends the last column-low tick, and holds that value after the access ends.
- R10: If a request is waiting when an access ends, it is accepted on the done tick. The row strobe is then high for S+1 ticks, which is at least the precharge of S ticks.
- R11: The row address is req_addr[ROW_W+COL_W-1:COL_W] and the column address is req_addr[COL_W-1:0]. Each is zero-extended to the bus width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the memory clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Row (upper bits) and column (lower bits) |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Block idle, a request is taken at this edge |
| cfg_cyc_len | input | 2 | Cycle-length select |
| cfg_row_tim | input | 2 | Row setup / precharge select |
| cfg_rcd_short | input | 1 | Short strobe-to-strobe delay |
| rsp_done | output | 1 | One-tick completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| dram_ras_n | output | 1 | Row address strobe, active low |
| dram_cas_n | output | 1 | Column address strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed address |
| dram_col_sel | output | 1 | 1 while the column address is driven |
| dram_dq_out | output | DATA_W | Write data to the pads |
| dram_dq_oe | output | 1 | Write data drive enable |
| dram_dq_in | input | DATA_W | Read data from the pads |

## Verification
Tick 0 is the first tick after the acceptance edge. The row strobe falls in tick S, the column select rises in tick S+D-1 and the column strobe falls in tick S+D. The strobes rise and rsp_done pulses in tick S+L. Read data is captured on the edge at the end of tick S+L-1.

The bench samples every output at the falling clock edge of each tick and records the tick number of each edge. It compares those numbers with S, D and L, which are entered by hand in the vector table. The pad read data is made valid only from tick S+D until just after the capture edge, so capturing one tick late or early returns a wrong value.

// File: rtl/fpm_seq_pkg.sv
package fpm_seq_pkg;

  localparam int TICK_W = 4;

  typedef logic [TICK_W-1:0] tick_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACTIVE = 2'd2
  } seq_state_e;

  // row setup before the row strobe falls, in half-clock ticks (11 behaves as 00)
  function automatic tick_t row_setup_ticks(input logic [1:0] row_tim);
    case (row_tim)
      2'b01:   return tick_t'(3);
      2'b10:   return tick_t'(2);
      default: return tick_t'(4);
    endcase
  endfunction

  // precharge requirement tracks the row setup selection
  function automatic tick_t prech_ticks(input logic [1:0] row_tim);
    return row_setup_ticks(row_tim);
  endfunction

  // row strobe to column strobe delay, in ticks
  function automatic tick_t strobe_gap_ticks(input logic [1:0] row_tim,
                                             input logic rcd_short);
    tick_t base;
    base = (row_tim == 2'b01) ? tick_t'(2) : tick_t'(3);
    return rcd_short ? base : base + tick_t'(2);
  endfunction

  // minimum total access length, setup plus row-low time, in ticks
  function automatic tick_t cycle_ticks(input logic [1:0] cyc_len);
    case (cyc_len)
      2'b01:   return tick_t'(8);
      2'b10:   return tick_t'(6);
      default: return tick_t'(10);
    endcase
  endfunction

  // row-low time: at least two column-low ticks, stretched to meet the cycle length
  function automatic tick_t row_low_ticks(input tick_t gap, input tick_t setup,
                                          input tick_t cyc);
    tick_t by_gap;
    tick_t by_cyc;
    by_gap = gap + tick_t'(2);
    by_cyc = cyc - setup;
    return (by_cyc > by_gap) ? by_cyc : by_gap;
  endfunction

endpackage

// File: rtl/fpm_tick_plan.sv
module fpm_tick_plan
  import fpm_seq_pkg::*;
(
  input  logic [1:0] cyc_len,
  input  logic [1:0] row_tim,
  input  logic       rcd_short,
  output tick_t      setup_t,
  output tick_t      gap_t,
  output tick_t      low_t,
  output tick_t      prech_t
);

  tick_t cyc_t;

  always_comb begin
    setup_t = row_setup_ticks(row_tim);
    gap_t   = strobe_gap_ticks(row_tim, rcd_short);
    cyc_t   = cycle_ticks(cyc_len);
    low_t   = row_low_ticks(gap_t, setup_t, cyc_t);
    prech_t = prech_ticks(row_tim);
  end

endmodule

// File: rtl/fpm_seq_ctrl.sv
module fpm_seq_ctrl
  import fpm_seq_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        cfg_cyc_len,
  input  logic [1:0]        cfg_row_tim,
  input  logic              cfg_rcd_short,
  output seq_state_e        state,
  output tick_t             cnt,
  output tick_t             gap_q,
  output tick_t             prech_q,
  output logic              write_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              accept,
  output logic              cycle_end
);

  tick_t setup_live, gap_live, low_live, prech_live;
  tick_t setup_q, low_q;
  logic  setup_last;

  fpm_tick_plan u_plan (
    .cyc_len   (cfg_cyc_len),
    .row_tim   (cfg_row_tim),
    .rcd_short (cfg_rcd_short),
    .setup_t   (setup_live),
    .gap_t     (gap_live),
    .low_t     (low_live),
    .prech_t   (prech_live)
  );

  assign accept     = (state == ST_IDLE) && req_valid;
  assign setup_last = (state == ST_SETUP) && (cnt == setup_q - tick_t'(1));
  assign cycle_end  = (state == ST_ACTIVE) && (cnt == low_q - tick_t'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      setup_q <= tick_t'(4);
      gap_q   <= tick_t'(5);
      low_q   <= tick_t'(7);
      prech_q <= tick_t'(4);
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_SETUP;
            cnt     <= '0;
            setup_q <= setup_live;
            gap_q   <= gap_live;
            low_q   <= low_live;
            prech_q <= prech_live;
            write_q <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
          end
        end
        ST_SETUP: begin
          if (setup_last) begin
            state <= ST_ACTIVE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + tick_t'(1);
          end
        end
        ST_ACTIVE: begin
          if (cycle_end) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + tick_t'(1);
          end
        end
        default: begin
          state <= ST_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/fpm_pin_drv.sv
module fpm_pin_drv
  import fpm_seq_pkg::*;
#(
  parameter int ROW_W  = 10,
  parameter int COL_W  = 9,
  parameter int DATA_W = 16,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  seq_state_e        state,
  input  tick_t             cnt,
  input  tick_t             gap_q,
  input  logic              write_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] wdata_q,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              oe_n,
  output logic              col_sel,
  output logic [MUX_W-1:0]  mux_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  logic             active;
  logic             col_phase;
  logic             cas_phase;
  logic [MUX_W-1:0] row_ext;
  logic [MUX_W-1:0] col_ext;

  generate
    if (MUX_W > ROW_W) begin : g_row_pad
      assign row_ext = {{(MUX_W-ROW_W){1'b0}}, addr_q[ADDR_W-1:COL_W]};
    end else begin : g_row_fit
      assign row_ext = addr_q[ADDR_W-1:COL_W];
    end
    if (MUX_W > COL_W) begin : g_col_pad
      assign col_ext = {{(MUX_W-COL_W){1'b0}}, addr_q[COL_W-1:0]};
    end else begin : g_col_fit
      assign col_ext = addr_q[COL_W-1:0];
    end
  endgenerate

  always_comb begin
    active    = (state == ST_ACTIVE);
    col_phase = active && (cnt >= gap_q - tick_t'(1));
    cas_phase = active && (cnt >= gap_q);
    ras_n     = !active;
    cas_n     = !cas_phase;
    col_sel   = col_phase;
    we_n      = !(col_phase && write_q);
    dq_oe     = cas_phase && write_q;
    oe_n      = !(cas_phase && !write_q);
    mux_addr  = col_phase ? col_ext : row_ext;
    dq_out    = dq_oe ? wdata_q : '0;
  end

endmodule

// File: rtl/fpm_rd_capture.sv
module fpm_rd_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cycle_end,
  input  logic              write_q,
  input  logic [DATA_W-1:0] dq_in,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done  <= 1'b0;
      rdata <= '0;
    end else begin
      done <= cycle_end;
      if (cycle_end && !write_q) rdata <= dq_in;
    end
  end

endmodule

// File: rtl/fpm_cycle_seq.sv
module fpm_cycle_seq
  import fpm_seq_pkg::*;
#(
  parameter int ROW_W  = 10,
  parameter int COL_W  = 9,
  parameter int DATA_W = 16,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  input  logic [1:0]        cfg_cyc_len,
  input  logic [1:0]        cfg_row_tim,
  input  logic              cfg_rcd_short,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [MUX_W-1:0]  dram_addr,
  output logic              dram_col_sel,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);

  seq_state_e        state;
  tick_t             cnt;
  tick_t             gap_q;
  tick_t             prech_q;
  logic              write_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              accept;
  logic              cycle_end;

  fpm_seq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_wdata     (req_wdata),
    .cfg_cyc_len   (cfg_cyc_len),
    .cfg_row_tim   (cfg_row_tim),
    .cfg_rcd_short (cfg_rcd_short),
    .state         (state),
    .cnt           (cnt),
    .gap_q         (gap_q),
    .prech_q       (prech_q),
    .write_q       (write_q),
    .addr_q        (addr_q),
    .wdata_q       (wdata_q),
    .accept        (accept),
    .cycle_end     (cycle_end)
  );

  fpm_pin_drv #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_pins (
    .state    (state),
    .cnt      (cnt),
    .gap_q    (gap_q),
    .write_q  (write_q),
    .addr_q   (addr_q),
    .wdata_q  (wdata_q),
    .ras_n    (dram_ras_n),
    .cas_n    (dram_cas_n),
    .we_n     (dram_we_n),
    .oe_n     (dram_oe_n),
    .col_sel  (dram_col_sel),
    .mux_addr (dram_addr),
    .dq_out   (dram_dq_out),
    .dq_oe    (dram_dq_oe)
  );

  fpm_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .cycle_end (cycle_end),
    .write_q   (write_q),
    .dq_in     (dram_dq_in),
    .done      (rsp_done),
    .rdata     (rsp_rdata)
  );

  assign req_ready = (state == ST_IDLE);

endmodule

// File: rtl/fpm_cycle_seq_chk.sv
module fpm_cycle_seq_chk
  import fpm_seq_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  ras_n,
  input logic  cas_n,
  input logic  we_n,
  input logic  col_sel,
  input logic  dq_oe,
  input logic  done,
  input logic  ready,
  input tick_t prech
);

  logic [TICK_W:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_run <= '0;
    else if (!ras_n) hi_run <= '0;
    else if (hi_run != '1) hi_run <= hi_run + 1'b1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (ras_n && cas_n && we_n && !dq_oe)); // R1
  AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n); // R4
  AST_COL_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $past(col_sel)); // R5
  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_sel) |-> $past(!ras_n)); // R5
  AST_DONE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (done && cas_n && ready)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_WDATA_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> $past(!we_n)); // R8
  AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> ($past(hi_run) >= {1'b0, prech})); // R10

endmodule

bind fpm_cycle_seq fpm_cycle_seq_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ras_n   (dram_ras_n),
  .cas_n   (dram_cas_n),
  .we_n    (dram_we_n),
  .col_sel (dram_col_sel),
  .dq_oe   (dram_dq_oe),
  .done    (rsp_done),
  .ready   (req_ready),
  .prech   (prech_q)
);

// File: tb/test_fpm_cycle_seq.sv
module test_fpm_cycle_seq;

  localparam int CLK_PERIOD = 10;
  localparam int ROW_W  = 10;
  localparam int COL_W  = 9;
  localparam int DATA_W = 16;
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int MUX_W  = 10;
  localparam int NV     = 12;

  typedef struct packed {
    logic [1:0] cyc;
    logic [1:0] row;
    logic       rs;
    logic       wr;
    int         su;
    int         gap;
    int         low;
  } vec_t;

  // hand-computed S, D, L per configuration
  localparam vec_t VECS [NV] = '{
    '{2'b00, 2'b00, 1'b0, 1'b0, 4, 5, 7},
    '{2'b00, 2'b00, 1'b1, 1'b1, 4, 3, 6},
    '{2'b01, 2'b01, 1'b0, 1'b0, 3, 4, 6},
    '{2'b01, 2'b01, 1'b1, 1'b1, 3, 2, 5},
    '{2'b10, 2'b10, 1'b1, 1'b0, 2, 3, 5},
    '{2'b10, 2'b10, 1'b0, 1'b1, 2, 5, 7},
    '{2'b00, 2'b10, 1'b1, 1'b0, 2, 3, 8},
    '{2'b01, 2'b11, 1'b1, 1'b1, 4, 3, 5},
    '{2'b11, 2'b01, 1'b1, 1'b0, 3, 2, 7},
    '{2'b11, 2'b11, 1'b0, 1'b1, 4, 5, 7},
    '{2'b10, 2'b01, 1'b1, 1'b1, 3, 2, 4},
    '{2'b00, 2'b01, 1'b1, 1'b0, 3, 2, 7}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              req_ready;
  logic [1:0]        cfg_cyc_len = 2'b00;
  logic [1:0]        cfg_row_tim = 2'b00;
  logic              cfg_rcd_short = 1'b0;
  logic              rsp_done;
  logic [DATA_W-1:0] rsp_rdata;
  logic              dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
  logic [MUX_W-1:0]  dram_addr;
  logic              dram_col_sel;
  logic [DATA_W-1:0] dram_dq_out;
  logic              dram_dq_oe;
  logic [DATA_W-1:0] dram_dq_in = '0;

  int checks = 0;
  int failures = 0;
  bit timed_out = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpm_cycle_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) i_fpm_cycle_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .cfg_cyc_len(cfg_cyc_len), .cfg_row_tim(cfg_row_tim), .cfg_rcd_short(cfg_rcd_short),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_addr(dram_addr), .dram_col_sel(dram_col_sel), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [MUX_W-1:0] row_of(input logic [ADDR_W-1:0] a);
    return MUX_W'(a >> COL_W);
  endfunction

  function automatic logic [MUX_W-1:0] col_of(input logic [ADDR_W-1:0] a);
    return MUX_W'(a & ((1 << COL_W) - 1));
  endfunction

  // one access; poke=1 holds a second request during the access and changes cfg
  task automatic run_vec(input vec_t v, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] wd, input bit poke);
    int ras_f = -1, ras_r = -1, cas_f = -1, cas_r = -1, col_r = -1;
    int we_f = -1, oe_f = -1, dq_r = -1, dn_t = -1, dn_cnt = 0, ras_falls = 0;
    bit prev_ras = 1;
    logic [DATA_W-1:0] good = wd ^ 16'h5A3C;
    int dtick = v.su + v.low;
    int ctick = v.su + v.gap;
    @(negedge clk);
    cfg_cyc_len = v.cyc; cfg_row_tim = v.row; cfg_rcd_short = v.rs;
    req_write = v.wr; req_addr = a; req_wdata = wd; req_valid = 1'b1;
    dram_dq_in = ~good;
    @(posedge clk);
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      if (prev_ras && !dram_ras_n) ras_falls++;
      prev_ras = dram_ras_n;
      if (ras_f < 0 && !dram_ras_n) ras_f = k;
      if (ras_f >= 0 && ras_r < 0 && dram_ras_n) ras_r = k;
      if (cas_f < 0 && !dram_cas_n) cas_f = k;
      if (cas_f >= 0 && cas_r < 0 && dram_cas_n) cas_r = k;
      if (col_r < 0 && dram_col_sel) col_r = k;
      if (we_f < 0 && !dram_we_n) we_f = k;
      if (oe_f < 0 && !dram_oe_n) oe_f = k;
      if (dq_r < 0 && dram_dq_oe) begin
        dq_r = k;
        chk(dram_dq_out == wd, "R8 write data", dram_dq_out, wd);
      end
      if (rsp_done) begin
        dn_cnt++;
        if (dn_t < 0) dn_t = k;
      end
      if (k == 0) chk(dram_addr == row_of(a), "R11 row address", dram_addr, row_of(a));
      if (k == ctick) chk(dram_addr == col_of(a), "R11 column address", dram_addr, col_of(a));
      if (k == dtick && !v.wr) chk(rsp_rdata == good, "R9 read capture", rsp_rdata, good);
      // stimulus after sampling
      if (k == 0) begin
        if (poke) begin
          cfg_cyc_len = ~v.cyc; cfg_row_tim = ~v.row; cfg_rcd_short = ~v.rs;
          req_addr = ~a;
        end else req_valid = 1'b0;
      end
      if (poke && k == dtick - 1) req_valid = 1'b0;
      if (k == ctick) dram_dq_in = good;
      if (k == dtick) dram_dq_in = ~good;
    end
    chk(ras_f == v.su, "R3 row strobe fall tick", ras_f, v.su);
    chk(cas_f == ctick, "R4 column strobe fall tick", cas_f, ctick);
    chk(col_r == ctick - 1, "R5 column select tick", col_r, ctick - 1);
    chk(ras_r == dtick, "R6 row strobe rise tick", ras_r, dtick);
    chk(cas_r == dtick && dn_t == dtick && dn_cnt == 1, "R7 done with strobe rise", dn_t, dtick);
    if (v.wr) begin
      chk(we_f == ctick - 1, "R8 write strobe tick", we_f, ctick - 1);
      chk(dq_r == ctick, "R8 data drive tick", dq_r, ctick);
      chk(oe_f == -1, "R8 output enable idle", oe_f, -1);
    end else begin
      chk(oe_f == ctick, "R9 output enable tick", oe_f, ctick);
      chk(we_f == -1, "R9 write strobe idle", we_f, -1);
      chk(rsp_rdata == good, "R9 read data held", rsp_rdata, good);
    end
    if (poke) chk(ras_falls == 1, "R2 busy request and cfg ignored", ras_falls, 1);
  endtask

  // two accesses with the request held across the done tick
  task automatic run_b2b(input logic [1:0] row, input int su);
    int rise1 = -1, fall2 = -1;
    bit prev_ras = 1;
    logic [ADDR_W-1:0] a2 = 19'h2A5B3;
    @(negedge clk);
    cfg_cyc_len = 2'b10; cfg_row_tim = row; cfg_rcd_short = 1'b1;
    req_write = 1'b0; req_addr = 19'h1F00F; req_valid = 1'b1;
    @(posedge clk);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (rise1 < 0 && !prev_ras && dram_ras_n) rise1 = k;
      if (rise1 >= 0 && fall2 < 0 && prev_ras && !dram_ras_n) begin
        fall2 = k;
        chk(dram_addr == row_of(a2), "R11 second row address", dram_addr, row_of(a2));
        req_valid = 1'b0;
      end
      prev_ras = dram_ras_n;
      if (k == 0) req_addr = a2;
    end
    chk(fall2 - rise1 == su + 1, "R10 back-to-back high time", fall2 - rise1, su + 1);
    chk(fall2 - rise1 >= su, "R10 precharge met", fall2 - rise1, su);
  endtask

  task automatic run_all;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes high in reset",
        {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hF);
    chk(!dram_col_sel && !dram_dq_oe, "R1 select and drive low in reset",
        {dram_col_sel, dram_dq_oe}, 0);
    chk(req_ready && !rsp_done, "R1 ready, no done in reset", {req_ready, rsp_done}, 2);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(dram_ras_n && req_ready && !rsp_done, "R1 idle after reset",
        {dram_ras_n, req_ready, rsp_done}, 6);
    for (int i = 0; i < NV; i++)
      run_vec(VECS[i], ADDR_W'(19'h0B3C5 + i * 19'h1357), DATA_W'(16'hC0DE + i * 16'h0111), 1'b0);
    // R2 busy request and configuration change during an access
    run_vec(VECS[0], 19'h3FE01, 16'h1234, 1'b1);
    run_vec(VECS[4], 19'h00001, 16'h4321, 1'b1);
    // R10 back-to-back at each precharge setting
    run_b2b(2'b00, 4);
    run_b2b(2'b01, 3);
    run_b2b(2'b10, 2);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule